// File: doc/BRIEF.md
# Day-Hour-Minute-Second Real-Time Clock Core

This core keeps calendar-free wall time as three counters: a day count, an hour/minute word and a seconds field. The counters advance by one second each time an external one-second strobe pulses while the core is running. A matching set of alarm registers is compared against the time on every advance. A match raises an alarm flag. Every running advance also raises a once-per-second flag.

Software reaches the core through a 16-bit register port. The port has separate write and read strobes and a 6-bit byte offset. Reads are combinational. The two flags live in a status register that is cleared by writing ones. An enable register masks the flags, and a single level interrupt is raised while any flag is set with its enable bit also set.

A two-state controller (`CORE_OFF`, `CORE_RUN`) follows the run bit of the control register. Transition START (`CORE_OFF` to `CORE_RUN`) is taken on a control write with bit 7 set. Transition STOP (`CORE_RUN` to `CORE_OFF`) is taken on a control write with bit 7 clear. In `CORE_OFF` the one-second strobe is ignored.

Top module: `rtc_dhms_core`

## Requirements
- R1: After reset every readable register returns 0 and `irq` is low; the controller is in `CORE_OFF`.
- R2: Time changes only on a cycle where `tick_1hz` is high and the controller is in `CORE_RUN`; strobes in `CORE_OFF` leave every time field unchanged.
- R3: Each advance increments seconds. Seconds roll from 59 to 0 and carry into minutes. Minutes roll from 59 to 0 and carry into hours. Hours roll from 23 to 0 and carry into the day count.
- R4: The day count is `DAY_W` bits wide and wraps from its maximum value to 0 on a carry.
- R5: A write to any time register (offsets 0x00, 0x04, 0x20) in the same cycle as a strobe stores the written value, and no increment happens in that cycle.
- R6: The time and alarm fields use these offsets:
  - 0x00 is time hour/minute, with hours in bits 15:8 and minutes in bits 7:0.
  - 0x04 is time seconds, in bits 5:0.
  - 0x20 is the time day count.
  - 0x08, 0x0C and 0x24 are the alarm hour/minute, alarm seconds and alarm day, with the same layouts as the time fields.
  - All of these read back what was written, within the field widths (hours 5 bits, minutes and seconds 6 bits).
- R7: The control register at 0x10 holds the run bit in bit 7 and the reference-frequency select in bits 6:5 (00 = 32768 Hz, 01 = 32000 Hz, 10 = 38400 Hz). Reads return both as written. Bit 7 reads 1 once running.
- R8: Status bit 2 (alarm) is set on the advance whose resulting day, hour, minute and second equal the alarm registers. It is never set in `CORE_OFF`.
- R9: Status bit 4 (one-second flag) is set on every strobe in `CORE_RUN`.
- R10: Status is at 0x14 and is cleared by writing ones. A one clears the bit and a zero leaves it. A flag being set in the same cycle wins over the clear.
- R11: The enable register is at 0x18 and implements bits 2 and 4 only. `irq` is high exactly when a status bit and its enable bit are both 1.
- R12: Unmapped offsets read 0, and status bit 0 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 6 | Byte offset of the register |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid while rd_en is high |
| irq | output | 1 | Level interrupt, status AND enable |

## Verification
The bench builds the core with `DAY_W = 3`, so the day count wraps after eight days. Starting points written next to that wrap let every rollover level be reached within a few ticks. From midnight on day 0, a sweep of more than an hour of consecutive ticks checks each step of the seconds and minutes carry chain against values derived by division of the elapsed tick count. Further starting points cover the hour-to-day carry and the 3-bit day wrap. Directed cases cover the write-versus-tick race, the alarm match with the core running and stopped, the clear-by-writing-ones race against a new flag, and masking of the interrupt.

// File: rtl/rtc_dhms_pkg.sv
package rtc_dhms_pkg;

    localparam int ADDR_W = 6;
    localparam int DATA_W = 16;

    localparam logic [ADDR_W-1:0] OFS_HM      = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_SEC     = 6'h04;
    localparam logic [ADDR_W-1:0] OFS_ALM_HM  = 6'h08;
    localparam logic [ADDR_W-1:0] OFS_ALM_SEC = 6'h0C;
    localparam logic [ADDR_W-1:0] OFS_CTL     = 6'h10;
    localparam logic [ADDR_W-1:0] OFS_STAT    = 6'h14;
    localparam logic [ADDR_W-1:0] OFS_IEN     = 6'h18;
    localparam logic [ADDR_W-1:0] OFS_DAY     = 6'h20;
    localparam logic [ADDR_W-1:0] OFS_ALM_DAY = 6'h24;

    localparam int CTL_RUN_BIT  = 7;
    localparam int CTL_FSEL_LO  = 5;
    localparam int FLAG_ALARM   = 2;
    localparam int FLAG_SECOND  = 4;

    localparam int HR_W = 5;
    localparam int MN_W = 6;
    localparam int SC_W = 6;

    typedef enum logic [0:0] {
        CORE_OFF = 1'b0,
        CORE_RUN = 1'b1
    } core_state_e;

    typedef struct packed {
        logic [HR_W-1:0] hr;
        logic [MN_W-1:0] mn;
        logic [SC_W-1:0] sc;
    } tod_t;

endpackage

// File: rtl/rtc_time_counter.sv
module rtc_time_counter
    import rtc_dhms_pkg::*;
#(
    parameter int DAY_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             wr_hm,
    input  logic             wr_sec,
    input  logic             wr_day,
    input  logic [HR_W-1:0]  wr_hr_val,
    input  logic [MN_W-1:0]  wr_mn_val,
    input  logic [SC_W-1:0]  wr_sc_val,
    input  logic [DAY_W-1:0] wr_day_val,
    output tod_t             tod_q,
    output logic [DAY_W-1:0] day_q,
    output tod_t             tod_nxt,
    output logic [DAY_W-1:0] day_nxt
);

    localparam logic [SC_W-1:0] SC_LAST = SC_W'(59);
    localparam logic [MN_W-1:0] MN_LAST = MN_W'(59);
    localparam logic [HR_W-1:0] HR_LAST = HR_W'(23);

    logic sc_wrap, mn_wrap, hr_wrap, any_wr;

    always_comb begin
        sc_wrap = (tod_q.sc == SC_LAST);
        mn_wrap = (tod_q.mn == MN_LAST);
        hr_wrap = (tod_q.hr == HR_LAST);
        any_wr  = wr_hm | wr_sec | wr_day;

        tod_nxt.sc = sc_wrap ? '0 : tod_q.sc + SC_W'(1);
        tod_nxt.mn = tod_q.mn;
        tod_nxt.hr = tod_q.hr;
        day_nxt    = day_q;
        if (sc_wrap) begin
            tod_nxt.mn = mn_wrap ? '0 : tod_q.mn + MN_W'(1);
            if (mn_wrap) begin
                tod_nxt.hr = hr_wrap ? '0 : tod_q.hr + HR_W'(1);
                if (hr_wrap) begin
                    day_nxt = day_q + DAY_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tod_q <= '0;
            day_q <= '0;
        end else if (any_wr) begin
            if (wr_hm) begin
                tod_q.hr <= wr_hr_val;
                tod_q.mn <= wr_mn_val;
            end
            if (wr_sec) begin
                tod_q.sc <= wr_sc_val;
            end
            if (wr_day) begin
                day_q <= wr_day_val;
            end
        end else if (step) begin
            tod_q <= tod_nxt;
            day_q <= day_nxt;
        end
    end

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !any_wr) |=> ($stable(tod_q) && $stable(day_q)));

    p_sec_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !any_wr && tod_q.sc == SC_LAST) |=> (tod_q.sc == '0));

    p_day_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !any_wr && tod_q.sc == SC_LAST && tod_q.mn == MN_LAST &&
         tod_q.hr == HR_LAST && day_q == '1) |=> (day_q == '0));

    p_wr_prio_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sec && step) |=> (tod_q.sc == $past(wr_sc_val)));

endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
    import rtc_dhms_pkg::*;
#(
    parameter int DAY_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_hm,
    input  logic             wr_sec,
    input  logic             wr_day,
    input  logic [HR_W-1:0]  wr_hr_val,
    input  logic [MN_W-1:0]  wr_mn_val,
    input  logic [SC_W-1:0]  wr_sc_val,
    input  logic [DAY_W-1:0] wr_day_val,
    input  logic             step,
    input  tod_t             tod_nxt,
    input  logic [DAY_W-1:0] day_nxt,
    output tod_t             alm_q,
    output logic [DAY_W-1:0] alm_day_q,
    output logic             hit
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            alm_q     <= '0;
            alm_day_q <= '0;
        end else begin
            if (wr_hm) begin
                alm_q.hr <= wr_hr_val;
                alm_q.mn <= wr_mn_val;
            end
            if (wr_sec) begin
                alm_q.sc <= wr_sc_val;
            end
            if (wr_day) begin
                alm_day_q <= wr_day_val;
            end
        end
    end

    // compare against the value the counters take on this advance
    always_comb begin
        hit = step && (tod_nxt == alm_q) && (day_nxt == alm_day_q);
    end

endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
    import rtc_dhms_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] set_vec,
    input  logic              wr_stat,
    input  logic              wr_ien,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] stat_q,
    output logic [DATA_W-1:0] ien_q,
    output logic              irq
);

    localparam logic [DATA_W-1:0] IMPL_MASK =
        DATA_W'((1 << FLAG_ALARM) | (1 << FLAG_SECOND));

    logic [DATA_W-1:0] clr_vec;
    logic [DATA_W-1:0] stat_d;

    always_comb begin
        clr_vec = wr_stat ? wdata : '0;
        stat_d  = ((stat_q & ~clr_vec) | set_vec) & IMPL_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
            ien_q  <= '0;
        end else begin
            stat_q <= stat_d;
            if (wr_ien) begin
                ien_q <= wdata & IMPL_MASK;
            end
        end
    end

    always_comb begin
        irq = |(stat_q & ien_q);
    end

    p_w1c_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && wdata[FLAG_SECOND] && !set_vec[FLAG_SECOND])
        |=> !stat_q[FLAG_SECOND]);

    p_alarm_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        set_vec[FLAG_ALARM] |=> stat_q[FLAG_ALARM]);

    p_irq_mask_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_q == '0) |-> !irq);

endmodule

// File: rtl/rtc_dhms_core.sv
module rtc_dhms_core
    import rtc_dhms_pkg::*;
#(
    parameter int DAY_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1hz,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);

    localparam int FSEL_W = 2;

    core_state_e       state_q, state_d;
    logic              run;
    logic [FSEL_W-1:0] fsel_q;

    logic wr_t_hm, wr_t_sec, wr_t_day, wr_a_hm, wr_a_sec, wr_a_day;
    logic wr_ctl, wr_stat, wr_ien, time_wr, adv, hit;

    tod_t             tod_q, tod_nxt, alm_q;
    logic [DAY_W-1:0] day_q, day_nxt, alm_day_q;
    logic [DATA_W-1:0] stat_q, ien_q, set_vec;

    always_comb begin
        wr_t_hm  = wr_en && (addr == OFS_HM);
        wr_t_sec = wr_en && (addr == OFS_SEC);
        wr_t_day = wr_en && (addr == OFS_DAY);
        wr_a_hm  = wr_en && (addr == OFS_ALM_HM);
        wr_a_sec = wr_en && (addr == OFS_ALM_SEC);
        wr_a_day = wr_en && (addr == OFS_ALM_DAY);
        wr_ctl   = wr_en && (addr == OFS_CTL);
        wr_stat  = wr_en && (addr == OFS_STAT);
        wr_ien   = wr_en && (addr == OFS_IEN);
        time_wr  = wr_t_hm | wr_t_sec | wr_t_day;
    end

    // controller: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CORE_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // controller: START and STOP transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CORE_OFF: if (wr_ctl && wdata[CTL_RUN_BIT])  state_d = CORE_RUN;
            CORE_RUN: if (wr_ctl && !wdata[CTL_RUN_BIT]) state_d = CORE_OFF;
        endcase
    end

    // controller: outputs
    always_comb begin
        run     = (state_q == CORE_RUN);
        adv     = run && tick_1hz && !time_wr;
        set_vec = '0;
        set_vec[FLAG_SECOND] = run && tick_1hz;
        set_vec[FLAG_ALARM]  = hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsel_q <= '0;
        end else if (wr_ctl) begin
            fsel_q <= wdata[CTL_FSEL_LO +: FSEL_W];
        end
    end

    rtc_time_counter #(.DAY_W(DAY_W)) u_time (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (adv),
        .wr_hm      (wr_t_hm),
        .wr_sec     (wr_t_sec),
        .wr_day     (wr_t_day),
        .wr_hr_val  (wdata[8 +: HR_W]),
        .wr_mn_val  (wdata[0 +: MN_W]),
        .wr_sc_val  (wdata[0 +: SC_W]),
        .wr_day_val (wdata[0 +: DAY_W]),
        .tod_q      (tod_q),
        .day_q      (day_q),
        .tod_nxt    (tod_nxt),
        .day_nxt    (day_nxt)
    );

    rtc_alarm_match #(.DAY_W(DAY_W)) u_alarm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_hm      (wr_a_hm),
        .wr_sec     (wr_a_sec),
        .wr_day     (wr_a_day),
        .wr_hr_val  (wdata[8 +: HR_W]),
        .wr_mn_val  (wdata[0 +: MN_W]),
        .wr_sc_val  (wdata[0 +: SC_W]),
        .wr_day_val (wdata[0 +: DAY_W]),
        .step       (adv),
        .tod_nxt    (tod_nxt),
        .day_nxt    (day_nxt),
        .alm_q      (alm_q),
        .alm_day_q  (alm_day_q),
        .hit        (hit)
    );

    rtc_irq_ctrl u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .wr_stat (wr_stat),
        .wr_ien  (wr_ien),
        .wdata   (wdata),
        .stat_q  (stat_q),
        .ien_q   (ien_q),
        .irq     (irq)
    );

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (addr)
                OFS_HM:      rdata = {3'b0, tod_q.hr, 2'b0, tod_q.mn};
                OFS_SEC:     rdata = {10'b0, tod_q.sc};
                OFS_DAY:     rdata = DATA_W'(day_q);
                OFS_ALM_HM:  rdata = {3'b0, alm_q.hr, 2'b0, alm_q.mn};
                OFS_ALM_SEC: rdata = {10'b0, alm_q.sc};
                OFS_ALM_DAY: rdata = DATA_W'(alm_day_q);
                OFS_CTL:     rdata = {8'b0, run, fsel_q, 5'b0};
                OFS_STAT:    rdata = stat_q;
                OFS_IEN:     rdata = ien_q;
                default:     rdata = '0;
            endcase
        end
    end

    p_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && wdata[CTL_RUN_BIT]) |=> (state_q == CORE_RUN));

    p_no_alarm_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CORE_OFF) |-> !hit);

endmodule

// File: tb/rtc_dhms_core_test.sv
`timescale 1ns/1ps
module rtc_dhms_core_test;

    localparam int DAY_W = 3;
    localparam int DAYS  = 1 << DAY_W;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_1hz = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [5:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    rtc_dhms_core #(.DAY_W(DAY_W)) uut (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .wr_en(wr_en),
        .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [15:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1;
        d = rdata;
        rd_en = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
        tick_1hz = 1'b1;
        @(negedge clk);
        tick_1hz = 1'b0;
    endtask

    task automatic set_time(input longint s);
        longint d, h, m, c;
        d = (s / 86400) % DAYS; h = (s / 3600) % 24;
        m = (s / 60) % 60;      c = s % 60;
        wr(6'h20, 16'(d));
        wr(6'h00, 16'((h << 8) | m));
        wr(6'h04, 16'(c));
    endtask

    task automatic chk_time(input string req, input longint s);
        logic [15:0] hm, sc, dy;
        longint d, h, m, c;
        d = (s / 86400) % DAYS; h = (s / 3600) % 24;
        m = (s / 60) % 60;      c = s % 60;
        rd(6'h20, dy); rd(6'h00, hm); rd(6'h04, sc);
        chk(req, {dy, hm, sc}, {16'(d), 16'((h << 8) | m), 16'(c)});
    endtask

    task automatic sweep(input string req, input longint s0, input int n);
        set_time(s0);
        for (int i = 1; i <= n; i++) begin
            tick();
            chk_time(req, s0 + i);
        end
    endtask

    initial begin
        #(5.0 * 190000);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        foreach (uut.rdata[i]) ; // no-op placeholder-free loop guard
        rd(6'h00, d); chk("R1 hm", d, 0);
        rd(6'h04, d); chk("R1 sec", d, 0);
        rd(6'h20, d); chk("R1 day", d, 0);
        rd(6'h10, d); chk("R1 ctl", d, 0);
        rd(6'h14, d); chk("R1 stat", d, 0);
        rd(6'h18, d); chk("R1 ien", d, 0);
        chk("R1 irq", irq, 0);

        // R2 strobes while stopped are ignored
        repeat (3) tick();
        chk_time("R2 stopped", 0);
        rd(6'h14, d); chk("R2 R9 no flag when stopped", d, 0);

        // R6 field layout and readback
        wr(6'h08, 16'h0A1B); rd(6'h08, d); chk("R6 alarm hm", d, 16'h0A1B);
        wr(6'h0C, 16'h002D); rd(6'h0C, d); chk("R6 alarm sec", d, 16'h002D);
        wr(6'h24, 16'h0005); rd(6'h24, d); chk("R6 alarm day", d, 16'h0005);
        wr(6'h00, 16'h1126); rd(6'h00, d); chk("R6 hm", d, 16'h1126);

        // R12 unmapped offsets
        rd(6'h1C, d); chk("R12 unmapped 1C", d, 0);
        rd(6'h28, d); chk("R12 unmapped 28", d, 0);

        // R7 control readback, start
        wr(6'h10, 16'h00C0); rd(6'h10, d); chk("R7 ctl run+fsel", d, 16'h00C0);
        wr(6'h10, 16'h00A0); rd(6'h10, d); chk("R7 ctl fsel 01", d, 16'h00A0);

        // R3 carry chain sweep over an hour
        sweep("R3 sweep", 0, 3700);
        // R3 hour-to-day carry, R4 day wrap
        sweep("R3 day carry", 86400 * 2 + 86395, 10);
        sweep("R4 day wrap", longint'(86400) * (DAYS - 1) + 86390, 20);

        // R9 one-second flag and R12 stopwatch bit
        wr(6'h14, 16'hFFFF);
        tick();
        rd(6'h14, d); chk("R9 second flag", d, 16'h0010);
        chk("R12 bit0 zero", d[0], 0);

        // R5 time write racing a strobe
        set_time(100);
        @(negedge clk);
        wr_en = 1'b1; addr = 6'h04; wdata = 16'd10; tick_1hz = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick_1hz = 1'b0;
        chk_time("R5 write wins", 70);

        // R8 alarm while running
        set_time(86400 + 2 * 3600 + 3 * 60 + 4);
        wr(6'h24, 16'h0001); wr(6'h08, 16'h0203); wr(6'h0C, 16'h0006);
        wr(6'h14, 16'hFFFF);
        tick();
        rd(6'h14, d); chk("R8 no match yet", d, 16'h0010);
        tick();
        rd(6'h14, d); chk("R8 match", d, 16'h0014);

        // R11 masking
        chk("R11 irq masked", irq, 0);
        wr(6'h18, 16'h0010); chk("R11 irq second", irq, 1);
        wr(6'h18, 16'hFFFF); rd(6'h18, d); chk("R11 ien bits", d, 16'h0014);

        // R10 clear by writing ones
        wr(6'h14, 16'h0004); rd(6'h14, d); chk("R10 clear alarm", d, 16'h0010);
        wr(6'h14, 16'h0000); rd(6'h14, d); chk("R10 zero no effect", d, 16'h0010);
        @(negedge clk);
        wr_en = 1'b1; addr = 6'h14; wdata = 16'h0010; tick_1hz = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick_1hz = 1'b0;
        rd(6'h14, d); chk("R10 set wins", d, 16'h0010);
        wr(6'h14, 16'h0010); rd(6'h14, d); chk("R10 clear second", d, 0);
        chk("R11 irq low", irq, 0);
        wr(6'h18, 16'h0004); tick();
        chk("R11 irq unenabled flag", irq, 0);

        // R8 and R2 stopped: no alarm, no advance
        wr(6'h10, 16'h0000); rd(6'h10, d); chk("R7 stop", d, 0);
        set_time(500);
        wr(6'h24, 16'h0000); wr(6'h08, 16'h0008); wr(6'h0C, 16'h0015);
        wr(6'h14, 16'hFFFF);
        tick();
        rd(6'h14, d); chk("R8 no alarm when stopped", d, 0);
        chk_time("R2 no advance when stopped", 500);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule